// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Error Flags

This block receives asynchronous serial characters on a single line. The line is sampled at sixteen times the bit rate, and an external tick paces that sampling. A frame is a low start bit, then 7 or 8 data bits with the least significant bit first, then an optional odd or even parity bit, then one or two stop bits. Each finished character goes into a single-entry receive buffer. Software reads the buffer through a simple register port.

Three faults are detected: overrun, framing and parity. Each fault sets a flag that stays set until software writes a 1 to that flag's bit. A faulty character is still stored, and the receiver keeps going. The buffer-full flag and the three error flags share one interrupt line, and each of the four causes has its own enable.

Top module: `uart_rx_errflags`

## Requirements
- R1: After reset, `rx_full`, `flag_ovr`, `flag_frm`, `flag_par` and `irq` are all 0.
- R2: A start bit is accepted only if the synchronized line is still low at the eighth oversample tick after the falling edge. A low pulse shorter than that delivers no character.
- R3: Data bits are sampled at the centre of each bit, least significant bit first. In 7-bit mode, bit 7 of `rd_data` reads 0.
- R4: With parity enabled, the parity bit is checked when the character moves into the buffer. `cfg_par_odd` selects the mode: 0 means even, 1 means odd. A mismatch sets `flag_par`, and the character is still stored.
- R5: A first stop bit sampled as 0 sets `flag_frm`. The character is still stored, and the next character is received normally.
- R6: With two stop bits configured, only the first stop bit is checked. A 0 in the second stop bit does not set `flag_frm`.
- R7: If a character completes while `rx_full` is 1 and no read happens in that cycle, the buffer takes the new character and `flag_ovr` is set.
- R8: A cycle with `wr_en` high clears each flag whose bit is 1 in `wr_data`. Bit 0 is overrun, bit 1 is framing and bit 2 is parity. Flags whose bits are 0 keep their value.
- R9: If an error is detected in the same cycle that a clear of that flag is written, the flag is set.
- R10: `rx_full` goes to 1 when a character is stored and returns to 0 on a cycle with `rd_en` high.
- R11: `irq` is 1 exactly when some cause is set and its enable bit is 1. `irq_en` bit 0 enables buffer full, bit 1 overrun, bit 2 framing and bit 3 parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx | input | 1 | Serial receive line, idle high |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| cfg_data8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | Two stop bits |
| irq_en | input | 4 | Per-cause interrupt enables |
| rd_en | input | 1 | Read strobe, empties the buffer |
| wr_en | input | 1 | Flag-clear write strobe |
| wr_data | input | 3 | Write-1-to-clear mask: {parity, framing, overrun} |
| rd_data | output | 8 | Receive buffer contents |
| rx_full | output | 1 | Buffer holds an unread character |
| flag_ovr | output | 1 | Overrun flag |
| flag_frm | output | 1 | Framing error flag |
| flag_par | output | 1 | Parity error flag |
| irq | output | 1 | Shared interrupt |

## Verification
The assertions check, on every cycle, the flag and buffer rules:
- an overwrite of an unread buffer leaves the overrun flag set;
- a flag with no clear aimed at it stays set;
- a detected error wins over a clear in the same cycle;
- a read empties the buffer;
- the delivery strobe is a single pulse that comes only from the stop-bit state.

Only the bench's scenarios can show the rest:
- that the bits are taken from the line in the right order and at the centre of each bit;
- that a short low glitch is rejected;
- that the second stop bit is ignored;
- that the parity result matches the configured mode over a full sweep of data values and formats.

// File: rtl/uart_rx_errflags_pkg.sv
package uart_rx_errflags_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic data8;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } rx_cfg_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              par_err;
        logic              frm_err;
    } rx_frame_t;

    // bit order matches the clear mask: {parity, framing, overrun}
    typedef struct packed {
        logic par;
        logic frm;
        logic ovr;
    } err_flags_t;

    // 1 when data plus parity bit disagree with the selected mode
    function automatic logic parity_fail(logic [DATA_W-1:0] d, logic pbit, logic odd);
        return (^d) ^ pbit ^ odd;
    endfunction

endpackage

// File: rtl/uart_rx_errflags_frame.sv
module uart_rx_errflags_frame
    import uart_rx_errflags_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rx,
    input  logic      os_tick,
    input  rx_cfg_t   cfg,
    output rx_frame_t frame
);

    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_s;
    rx_state_e              state;
    logic [CNT_W-1:0]       cnt;
    logic [2:0]             bit_idx;
    logic [DATA_W-1:0]      shreg;
    logic                   pbit;
    logic                   line_hi;
    logic [DATA_W-1:0]      asm_data;
    logic [2:0]             last_bit;
    logic                   at_last;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx};
    end
    assign rx_s = sync_q[SYNC_STAGES-1];

    assign asm_data = cfg.data8 ? shreg : {1'b0, shreg[DATA_W-1:1]};
    assign last_bit = cfg.data8 ? 3'd7 : 3'd6;
    assign at_last  = (cnt == LAST_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            pbit    <= 1'b0;
            line_hi <= 1'b0;
            frame   <= '0;
        end else begin
            frame.valid <= 1'b0;
            if (os_tick) begin
                case (state)
                    ST_IDLE: begin
                        cnt     <= '0;
                        line_hi <= rx_s;
                        if (!rx_s && line_hi) state <= ST_START;
                    end
                    ST_START: begin
                        if (cnt == MID_CNT) begin
                            cnt     <= '0;
                            bit_idx <= '0;
                            line_hi <= 1'b0;
                            state   <= rx_s ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        cnt <= cnt + 1'b1;
                        if (at_last) begin
                            shreg <= {rx_s, shreg[DATA_W-1:1]};
                            if (bit_idx == last_bit)
                                state <= cfg.par_en ? ST_PAR : ST_STOP1;
                            else
                                bit_idx <= bit_idx + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        cnt <= cnt + 1'b1;
                        if (at_last) begin
                            pbit  <= rx_s;
                            state <= ST_STOP1;
                        end
                    end
                    ST_STOP1: begin
                        cnt <= cnt + 1'b1;
                        if (at_last) begin
                            frame.valid   <= 1'b1;
                            frame.data    <= asm_data;
                            frame.frm_err <= !rx_s;
                            frame.par_err <= cfg.par_en &&
                                             parity_fail(asm_data, pbit, cfg.par_odd);
                            line_hi       <= 1'b0;
                            state         <= cfg.two_stop ? ST_STOP2 : ST_IDLE;
                        end
                    end
                    ST_STOP2: begin
                        cnt <= cnt + 1'b1;
                        if (at_last) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        frame.valid |=> !frame.valid);

    assert_deliver_from_stop_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(frame.valid) |-> $past(state) == ST_STOP1);

endmodule

// File: rtl/uart_rx_errflags_buf.sv
module uart_rx_errflags_buf
    import uart_rx_errflags_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rx_frame_t         frame,
    input  logic              rd_en,
    input  logic              wr_en,
    input  err_flags_t        wr_clr,
    input  logic [3:0]        irq_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output err_flags_t        flags,
    output logic              irq
);

    err_flags_t set_ev;
    err_flags_t clr_ev;

    assign set_ev.ovr = frame.valid && full && !rd_en;
    assign set_ev.frm = frame.valid && frame.frm_err;
    assign set_ev.par = frame.valid && frame.par_err;
    assign clr_ev     = wr_en ? wr_clr : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            full    <= 1'b0;
            flags   <= '0;
        end else begin
            if (frame.valid) begin
                rd_data <= frame.data;
                full    <= 1'b1;
            end else if (rd_en) begin
                full <= 1'b0;
            end
            flags <= set_ev | (flags & ~clr_ev);
        end
    end

    assign irq = |(irq_en & {flags.par, flags.frm, flags.ovr, full});

    assert_ovr_on_overwrite_R7: assert property (@(posedge clk) disable iff (rst)
        (frame.valid && full && !rd_en) |=> flags.ovr);

    assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (frame.valid && frame.par_err) |=> flags.par);

    assert_frm_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (flags.frm && !(wr_en && wr_clr.frm)) |=> flags.frm);

    assert_read_empties_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !frame.valid) |=> !full);

    assert_irq_masked_R11: assert property (@(posedge clk) disable iff (rst)
        (irq_en == 4'b0000) |-> !irq);

endmodule

// File: rtl/uart_rx_errflags.sv
module uart_rx_errflags
    import uart_rx_errflags_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx,
    input  logic              os_tick,
    input  logic              cfg_data8,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic [3:0]        irq_en,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [2:0]        wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_full,
    output logic              flag_ovr,
    output logic              flag_frm,
    output logic              flag_par,
    output logic              irq
);

    rx_cfg_t    cfg;
    rx_frame_t  frame;
    err_flags_t flags;
    err_flags_t wr_clr;

    assign cfg    = '{data8: cfg_data8, par_en: cfg_par_en,
                      par_odd: cfg_par_odd, two_stop: cfg_two_stop};
    assign wr_clr = err_flags_t'(wr_data);

    uart_rx_errflags_frame #(
        .OVERSAMPLE (OVERSAMPLE),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_frame (
        .clk    (clk),
        .rst    (rst),
        .rx     (rx),
        .os_tick(os_tick),
        .cfg    (cfg),
        .frame  (frame)
    );

    uart_rx_errflags_buf u_buf (
        .clk    (clk),
        .rst    (rst),
        .frame  (frame),
        .rd_en  (rd_en),
        .wr_en  (wr_en),
        .wr_clr (wr_clr),
        .irq_en (irq_en),
        .rd_data(rd_data),
        .full   (rx_full),
        .flags  (flags),
        .irq    (irq)
    );

    assign flag_ovr = flags.ovr;
    assign flag_frm = flags.frm;
    assign flag_par = flags.par;

endmodule

// File: tb/uart_rx_errflags_bench.sv
module uart_rx_errflags_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 2;
    localparam int BIT_CLK    = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx  = 1'b1;
    logic       os_tick = 1'b0;
    logic       cfg_data8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic [3:0] irq_en = 4'h0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [2:0] wr_data = 3'b000;
    logic [7:0] rd_data;
    logic       rx_full, flag_ovr, flag_frm, flag_par, irq;

    int n_checks = 0;
    int n_fails  = 0;
    int tick_cnt = 0;
    logic mon_en = 1'b0;
    logic par_seen = 1'b0;

    uart_rx_errflags u_uart_rx_errflags (
        .clk(clk), .rst(rst), .rx(rx), .os_tick(os_tick),
        .cfg_data8(cfg_data8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .irq_en(irq_en), .rd_en(rd_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .rx_full(rx_full),
        .flag_ovr(flag_ovr), .flag_frm(flag_frm), .flag_par(flag_par), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        tick_cnt = (tick_cnt + 1) % TICK_DIV;
        os_tick  = (tick_cnt == 0);
        if (mon_en && flag_par) par_seen = 1'b1;
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        rx = v;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    // sends one character; bad_par flips the parity bit, s1/s2 are stop bit levels
    task automatic send(input logic [7:0] d, input logic bad_par,
                        input logic s1, input logic s2);
        int nb;
        logic p;
        nb = cfg_data8 ? 8 : 7;
        p  = cfg_par_odd;
        hold_bit(1'b0);
        for (int k = 0; k < nb; k++) begin
            hold_bit(d[k]);
            p = p ^ d[k];
        end
        if (cfg_par_en) hold_bit(p ^ bad_par);
        hold_bit(s1);
        if (cfg_two_stop) hold_bit(s2);
        hold_bit(1'b1);
    endtask

    task automatic do_read();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_clear(input logic [2:0] m);
        wr_en = 1'b1;
        wr_data = m;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 3'b000;
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic d8, input logic pe, input logic po, input logic ts);
        cfg_data8 = d8; cfg_par_en = pe; cfg_par_odd = po; cfg_two_stop = ts;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] exp_d;
        irq_en = 4'hF;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 full", {7'd0, rx_full}, 8'd0);
        check("R1 flags", {5'd0, flag_par, flag_frm, flag_ovr}, 8'd0);
        check("R1 irq", {7'd0, irq}, 8'd0);
        hold_bit(1'b1);

        // R2 glitch shorter than half a bit
        rx = 1'b0;
        repeat (6 * TICK_DIV) @(negedge clk);
        hold_bit(1'b1);
        hold_bit(1'b1);
        check("R2 glitch rejected", {7'd0, rx_full}, 8'd0);

        // sweep of data values and formats
        irq_en = 4'b0001;
        for (int i = 0; i < 256; i++) begin
            set_cfg((i % 3) != 0, i[1], i[2], i[3]);
            exp_d = cfg_data8 ? 8'(i) : (8'(i) & 8'h7F);
            send(8'(i), 1'b0, 1'b1, 1'b1);
            check("R3 data", rd_data, exp_d);
            check("R4 no false error", {5'd0, flag_par, flag_frm, flag_ovr}, 8'd0);
            check("R11 irq on full", {7'd0, irq}, 8'd1);
            do_read();
            check("R10 read empties", {7'd0, rx_full}, 8'd0);
            check("R11 irq after read", {7'd0, irq}, 8'd0);
        end

        // R4 parity errors, even then odd
        irq_en = 4'h0;
        set_cfg(1'b1, 1'b1, 1'b0, 1'b0);
        send(8'h5A, 1'b1, 1'b1, 1'b1);
        check("R4 even mismatch flag", {7'd0, flag_par}, 8'd1);
        check("R4 data stored", rd_data, 8'h5A);
        check("R11 masked irq", {7'd0, irq}, 8'd0);
        irq_en = 4'b1000;
        @(negedge clk);
        check("R11 parity irq", {7'd0, irq}, 8'd1);
        irq_en = 4'h0;
        do_read();
        do_clear(3'b100);
        check("R8 parity cleared", {7'd0, flag_par}, 8'd0);
        set_cfg(1'b0, 1'b1, 1'b1, 1'b0);
        send(8'h33, 1'b1, 1'b1, 1'b1);
        check("R4 odd mismatch flag", {7'd0, flag_par}, 8'd1);
        check("R4 odd data stored", rd_data, 8'h33);
        do_read();
        do_clear(3'b100);

        // R5 framing error, then a clean character
        set_cfg(1'b1, 1'b0, 1'b0, 1'b0);
        send(8'hC3, 1'b0, 1'b0, 1'b1);
        check("R5 frm flag", {7'd0, flag_frm}, 8'd1);
        check("R5 data stored", rd_data, 8'hC3);
        do_read();
        send(8'h81, 1'b0, 1'b1, 1'b1);
        check("R5 next received", rd_data, 8'h81);
        check("R5 next full", {7'd0, rx_full}, 8'd1);
        do_read();
        do_clear(3'b101);
        check("R8 frm kept", {7'd0, flag_frm}, 8'd1);
        do_clear(3'b010);
        check("R8 frm cleared", {7'd0, flag_frm}, 8'd0);

        // R6 second stop bit ignored, first still checked
        set_cfg(1'b1, 1'b0, 1'b0, 1'b1);
        send(8'h6E, 1'b0, 1'b1, 1'b0);
        check("R6 no frm on stop2", {7'd0, flag_frm}, 8'd0);
        check("R6 data", rd_data, 8'h6E);
        do_read();
        send(8'h17, 1'b0, 1'b0, 1'b1);
        check("R6 stop1 checked", {7'd0, flag_frm}, 8'd1);
        do_read();
        do_clear(3'b010);

        // R7 overrun
        set_cfg(1'b1, 1'b0, 1'b0, 1'b0);
        send(8'hA1, 1'b0, 1'b1, 1'b1);
        send(8'hB2, 1'b0, 1'b1, 1'b1);
        check("R7 overwritten", rd_data, 8'hB2);
        check("R7 ovr flag", {7'd0, flag_ovr}, 8'd1);
        irq_en = 4'b0010;
        @(negedge clk);
        check("R11 ovr irq", {7'd0, irq}, 8'd1);
        irq_en = 4'h0;
        do_read();
        do_clear(3'b001);
        check("R8 ovr cleared", {5'd0, flag_par, flag_frm, flag_ovr}, 8'd0);

        // R9 set wins over a clear held through detection
        set_cfg(1'b1, 1'b1, 1'b0, 1'b0);
        wr_en = 1'b1;
        wr_data = 3'b100;
        par_seen = 1'b0;
        mon_en = 1'b1;
        send(8'h0F, 1'b1, 1'b1, 1'b1);
        mon_en = 1'b0;
        wr_en = 1'b0;
        wr_data = 3'b000;
        @(negedge clk);
        check("R9 set beats clear", {7'd0, par_seen}, 8'd1);
        check("R9 later cleared", {7'd0, flag_par}, 8'd0);
        do_read();

        finish_run();
    end

endmodule